// File: doc/BRIEF.md
# Staged Asynchronous Memory Read Sequencer

This block runs read cycles on a bank of asynchronous memories that share one data bus. A host raises a request together with a full address. The top address bits choose one device, and the rest form the word address. The sequencer first drives the word address with every device deselected. It then selects the chosen device by pulling its active-low chip select low and waits out the slow internal access time. Only after that does it pull the shared active-low output enable low, and for a shorter window.

On the last cycle of the output-enable window the sequencer captures the bus and presents the word with a single-cycle done pulse. It always releases output enable before chip select. It then spends one idle cycle with everything released before it takes the next request.

The two waits are separate parameters. The long access wait overlaps with the device being selected, so only the short output-enable count holds the bus. While a read is in progress, further requests are dropped.

Top module: `amrs_read_seq`

## Requirements
- R1: While reset is asserted and after it is released, all chip selects and the output enable are high, busy is low and done is low.
- R2: A request raised while busy is low is accepted at the next clock edge. In the following cycle busy is high, the word address (the low ADDR_W-SEL_W address bits) is driven and every chip select is still high. The word address does not change until the next accepted request.
- R3: After the address cycle, the chosen chip select stays low with output enable high for exactly T_AA cycles.
- R4: Output enable is then low for exactly T_OE cycles while the chip select stays low. The bus value on the last of those cycles is the read data.
- R5: At most one chip select is ever low. The low one is bit i of the select vector, where i is the value of the top SEL_W bits of the requested address.
- R6: Output enable is low only while a chip select is low.
- R7: In the cycle after the last output-enable cycle, done is high for exactly one cycle and the read data output holds the captured word. In that cycle output enable is already high and the chip select is still low, so output enable is released first.
- R8: The cycle after the done cycle has every chip select and output enable high with busy still high. Busy is low in the cycle after that, and a request is accepted no earlier.
- R9: Busy stays high from the cycle after acceptance through the turnaround cycle. A request made while busy is high starts no cycle and does not change the word address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request, sampled while idle |
| addr_i | input | ADDR_W | Full read address: device bits on top, word bits below |
| busy_o | output | 1 | High while a read or its turnaround is in progress |
| done_o | output | 1 | One-cycle pulse when rdata_o is valid |
| rdata_o | output | DATA_W | Captured read word |
| mem_addr_o | output | ADDR_W-SEL_W | Word address to the memories |
| mem_ce_n_o | output | 2**SEL_W | Active-low chip select, one bit per device |
| mem_oe_n_o | output | 1 | Shared active-low output enable |
| mem_dq_i | input | DATA_W | Shared data bus from the memories |

## Verification
The bench builds the block with T_AA=5, T_OE=2, ADDR_W=10, SEL_W=2 and DATA_W=8. The unequal waits separate the select-only window from the output-enable window, so a timer loaded with the wrong count shows up at the ports. Four devices let the vectors hit the lowest and highest select index. The bench memory model drives a device-specific word only while one select and the output enable are both low, so a capture on the wrong cycle returns a visibly wrong word.

// File: rtl/amrs_pkg.sv
package amrs_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_ADDR = 3'd1,
    S_SEL  = 3'd2,
    S_DRV  = 3'd3,
    S_REL  = 3'd4,
    S_TURN = 3'd5
  } amrs_state_e;

  // Device index held in the top bits of a full address.
  function automatic int unsigned dev_of(input logic [31:0] addr,
                                         input int unsigned addr_w,
                                         input int unsigned sel_w);
    return int'(addr >> (addr_w - sel_w)) & ((1 << sel_w) - 1);
  endfunction

  // Clock edges from accepting a request until the next one can be accepted.
  function automatic int unsigned cycle_len(input int unsigned t_aa,
                                            input int unsigned t_oe);
    return 4 + t_aa + t_oe;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/amrs_phase_timer.sv
module amrs_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/amrs_dev_decode.sv
module amrs_dev_decode #(
  parameter int SEL_W = 2,
  localparam int NDEV = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] idx_i,
  input  logic             en_i,
  output logic [NDEV-1:0]  ce_n_o
);
  for (genvar g = 0; g < NDEV; g++) begin : g_dev
    assign ce_n_o[g] = !(en_i && (idx_i == SEL_W'(g)));
  end
endmodule

// File: rtl/amrs_read_seq.sv
module amrs_read_seq
  import amrs_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2,
  parameter int T_AA   = 5,
  parameter int T_OE   = 2,
  localparam int MA_W  = ADDR_W - SEL_W,
  localparam int NDEV  = 1 << SEL_W,
  localparam int CNT_W = $clog2(max2(T_AA, T_OE) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [MA_W-1:0]   mem_addr_o,
  output logic [NDEV-1:0]   mem_ce_n_o,
  output logic              mem_oe_n_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  amrs_state_e state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] rdata_q;
  logic              done_q;

  // Named internal events, also used by the checker.
  logic accept, phase_last, aa_done, oe_done, tmr_load, ce_on, oe_on;
  logic [CNT_W-1:0] tmr_val;

  assign accept   = req_i && (state_q == S_IDLE);
  assign aa_done  = (state_q == S_SEL) && phase_last;
  assign oe_done  = (state_q == S_DRV) && phase_last;
  assign tmr_load = (state_q == S_ADDR) || aa_done;
  assign tmr_val  = (state_q == S_ADDR) ? CNT_W'(T_AA) : CNT_W'(T_OE);
  assign ce_on    = (state_q == S_SEL) || (state_q == S_DRV) || (state_q == S_REL);
  assign oe_on    = (state_q == S_DRV);

  amrs_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .last_o    (phase_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (accept)   state_d = S_ADDR;
      S_ADDR:               state_d = S_SEL;
      S_SEL:  if (aa_done)  state_d = S_DRV;
      S_DRV:  if (oe_done)  state_d = S_REL;
      S_REL:                state_d = S_TURN;
      S_TURN:               state_d = S_IDLE;
      default:              state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= oe_done;
      if (accept)  addr_q  <= addr_i;
      if (oe_done) rdata_q <= mem_dq_i;
    end
  end

  amrs_dev_decode #(.SEL_W(SEL_W)) u_dec (
    .idx_i (addr_q[ADDR_W-1:MA_W]),
    .en_i  (ce_on),
    .ce_n_o(mem_ce_n_o)
  );

  assign mem_oe_n_o = !oe_on;
  assign mem_addr_o = addr_q[MA_W-1:0];
  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = done_q;
  assign rdata_o    = rdata_q;
endmodule

// File: rtl/amrs_read_seq_chk.sv
module amrs_read_seq_chk #(
  parameter int T_AA = 5,
  parameter int T_OE = 2,
  parameter int NDEV = 4,
  parameter int MA_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy_o,
  input logic            done_o,
  input logic [MA_W-1:0] mem_addr_o,
  input logic [NDEV-1:0] mem_ce_n_o,
  input logic            mem_oe_n_o,
  input logic            accept
);
  logic any_ce;
  assign any_ce = !(&mem_ce_n_o);

  // Window counters for the two timed phases.
  int unsigned sel_cnt, drv_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_cnt <= 0;
      drv_cnt <= 0;
    end else begin
      sel_cnt <= (any_ce && mem_oe_n_o) ? sel_cnt + 1 : 0;
      drv_cnt <= (!mem_oe_n_o) ? drv_cnt + 1 : 0;
    end
  end

  p_idle_in_reset_r1: assert property (@(posedge clk)
    !rst_n |-> (&mem_ce_n_o && mem_oe_n_o && !busy_o && !done_o));

  p_addr_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy_o && &mem_ce_n_o && mem_oe_n_o));

  p_addr_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(mem_addr_o));

  p_aa_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n_o) |-> (sel_cnt == T_AA));

  p_oe_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n_o) |-> (drv_cnt == T_OE));

  p_one_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~mem_ce_n_o) <= 1);

  p_oe_needs_ce_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n_o |-> any_ce);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_oe_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (mem_oe_n_o && any_ce));

  p_turnaround_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (busy_o && &mem_ce_n_o && mem_oe_n_o));
endmodule

bind amrs_read_seq amrs_read_seq_chk #(
  .T_AA(T_AA), .T_OE(T_OE), .NDEV(NDEV), .MA_W(MA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .mem_addr_o(mem_addr_o),
  .mem_ce_n_o(mem_ce_n_o),
  .mem_oe_n_o(mem_oe_n_o),
  .accept    (accept)
);

// File: tb/amrs_read_seq_tb.sv
module amrs_read_seq_tb;
  localparam int ADDR_W = 10, DATA_W = 8, SEL_W = 2, T_AA = 5, T_OE = 2;
  localparam int MA_W = ADDR_W - SEL_W, NDEV = 1 << SEL_W;
  localparam logic [ADDR_W-1:0] VEC [6] =
    '{10'h000, 10'h3FF, 10'h155, 10'h2AA, 10'h1C3, 10'h0FE};

  logic clk = 0, rst_n = 0, req = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic busy, done, oe_n;
  logic [DATA_W-1:0] rdata, dq;
  logic [MA_W-1:0] maddr;
  logic [NDEV-1:0] ce_n;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  amrs_read_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W),
                  .T_AA(T_AA), .T_OE(T_OE)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .addr_i(addr),
    .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .mem_addr_o(maddr), .mem_ce_n_o(ce_n), .mem_oe_n_o(oe_n), .mem_dq_i(dq));

  // Device word: word address xor device tag; bus idles at 8'hEE.
  function automatic logic [DATA_W-1:0] word_of(input int dev, input logic [MA_W-1:0] wa);
    return wa ^ DATA_W'(dev << 6) ^ 8'h3C;
  endfunction

  always_comb begin
    dq = 8'hEE;
    for (int i = 0; i < NDEV; i++)
      if (!ce_n[i] && !oe_n && $countones(~ce_n) == 1) dq = word_of(i, maddr);
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic logic [NDEV-1:0] ce_exp(input int dev);
    return ~(NDEV'(1) << dev);
  endfunction

  // Full read; poke_k >= 0 raises a stray request with poke_a in that cycle.
  task automatic run_read(input logic [ADDR_W-1:0] a, input int poke_k,
                          input logic [ADDR_W-1:0] poke_a);
    int dev = int'(a >> MA_W);
    logic [MA_W-1:0] wa = a[MA_W-1:0];
    int last = T_AA + T_OE + 2;
    @(negedge clk); req = 1; addr = a;
    @(negedge clk); req = 0;
    for (int k = 0; k <= last; k++) begin
      if (k > 0) @(negedge clk);
      req = (k == poke_k); if (k == poke_k) addr = poke_a;
      chk(maddr == wa, "R2 R9 word address", maddr, wa);
      chk(busy, "R9 busy", busy, 1);
      if (k == 0)
        chk(&ce_n && oe_n, "R2 address cycle", {ce_n, oe_n}, {{NDEV{1'b1}}, 1'b1});
      else if (k <= T_AA)
        chk(ce_n == ce_exp(dev) && oe_n, "R3 R5 select phase", {ce_n, oe_n}, {ce_exp(dev), 1'b1});
      else if (k <= T_AA + T_OE)
        chk(ce_n == ce_exp(dev) && !oe_n && !done, "R4 R6 enable phase", {ce_n, oe_n}, {ce_exp(dev), 1'b0});
      else if (k == T_AA + T_OE + 1) begin
        chk(done, "R7 done pulse", done, 1);
        chk(rdata == word_of(dev, wa), "R4 R7 read data", rdata, word_of(dev, wa));
        chk(oe_n && ce_n == ce_exp(dev), "R7 oe released first", {ce_n, oe_n}, {ce_exp(dev), 1'b1});
      end else
        chk(!done && &ce_n && oe_n, "R8 turnaround", {done, ce_n, oe_n}, {1'b0, {NDEV{1'b1}}, 1'b1});
    end
    req = 0;
    @(negedge clk);
    chk(!busy, "R8 idle after turnaround", busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    chk(&ce_n && oe_n && !busy && !done, "R1 in reset", {ce_n, oe_n, busy, done}, {{NDEV{1'b1}}, 3'b100});
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(&ce_n && oe_n && !busy && !done, "R1 after reset", {ce_n, oe_n, busy, done}, {{NDEV{1'b1}}, 3'b100});

    foreach (VEC[i]) run_read(VEC[i], -1, '0);

    // R9: stray requests in the select, enable and done cycles are dropped.
    run_read(10'h2C1, 2, 10'h07F);
    run_read(10'h0A5, T_AA + 1, 10'h3C3);
    run_read(10'h31E, T_AA + T_OE + 1, 10'h111);
    repeat (3) begin
      @(negedge clk);
      chk(!busy && &ce_n && oe_n, "R9 stray request ignored", {busy, ce_n}, {1'b0, {NDEV{1'b1}}});
    end

    // R8: request held through turnaround is taken only after the idle cycle.
    @(negedge clk); req = 1; addr = 10'h123;
    @(negedge clk); addr = 10'h3AB;
    repeat (T_AA + T_OE + 2) @(negedge clk);
    chk(busy && &ce_n, "R8 turnaround while request held", busy, 1);
    @(negedge clk);
    chk(!busy, "R8 one idle cycle", busy, 0);
    @(negedge clk); req = 0;
    chk(busy && maddr == 8'hAB, "R8 R2 next request accepted", maddr, 8'hAB);
    repeat (T_AA + T_OE + 4) @(negedge clk);
    chk(!busy, "R8 back to idle", busy, 0);

    // R1: reset in the middle of the enable phase.
    @(negedge clk); req = 1; addr = 10'h300;
    @(negedge clk); req = 0;
    repeat (T_AA + 1) @(negedge clk);
    chk(!oe_n, "R4 enable phase reached", oe_n, 0);
    rst_n = 0; #1;
    chk(&ce_n && oe_n && !busy && !done, "R1 reset mid read", {ce_n, oe_n, busy}, {{NDEV{1'b1}}, 2'b10});
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk(!busy && &ce_n, "R1 idle after mid-read reset", busy, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule